// File: doc/BRIEF.md
# Cache-Only Memory Directory with Master-Copy Tracking

This block is the directory controller for a machine in which every node keeps shared data in a large local cache, and no block of data has a home memory. The directory position of each block address is fixed. The block itself can live on any set of nodes. For every block the controller records which nodes hold a copy. It also records which one of those nodes holds the master copy, which is the copy that must never be dropped. Read misses, writes and master evictions arrive on one request port. The controller looks up the block, tells the current master to supply data, sends invalidates to the other holders on a write, and gives the master role to another node when the current master gives up its copy.

Each accepted request gets exactly one response. A read that hits a valid block is answered in the cycle after acceptance, together with a forward message to the master. A write to a block that other nodes share is held until every invalidated node has acknowledged. A master eviction first promotes an existing sharer, without moving data. If there is no other sharer, it moves the master copy to a node that reports free capacity. If no node has room, the controller raises a stall flag and keeps the eviction open until a node reports room.

Only one long transaction, meaning a write that waits for acknowledgements or an eviction that waits for capacity, can be open at a time. Other requests that clash with it are answered with a retry code, and the requester sends them again.

Top module: `amd_directory`

## Requirements
- R1: After reset, rsp_valid, fwd_valid, inv_valid and stall_err are low, req_ready is high, and every block is untracked.
- R2: A read (req_op 0) of an untracked block is answered one cycle after acceptance with code 0 (first touch). rsp_src equals the requester, and the requester becomes the sole holder and the master. No forward is issued.
- R3: A read of a tracked block by a node that does not hold it is answered one cycle after acceptance with code 1 (read grant), rsp_src set to the master, and a forward pulse from the master to the requester. A reread by a current holder gives code 1 with no forward.
- R4: A write (req_op 1) to a block that other nodes share sends, one cycle after acceptance, a single invalidate pulse whose vector is exactly those other sharers. Code 2 (write grant) is sent the cycle after the last of those nodes acknowledges on ack_vec, and rsp_src is the previous master.
- R5: A write to an untracked block, or by the sole holder, is granted with code 2 one cycle after acceptance and sends no invalidate.
- R6: After a write completes, the writer is the only holder and the master. A later read by another node is forwarded from the writer.
- R7: An eviction (req_op 2) by the master of a block with other sharers makes the lowest-numbered other sharer the master. It answers code 3 (evict done) with rsp_src set to the new master, and issues no forward.
- R8: An eviction by the sole holder picks the lowest-numbered node other than the evictor whose bit is set in free_vec. It forwards from the evictor to that node and answers code 3 with rsp_src set to that node.
- R9: If no such node exists, no response is given, stall_err rises one cycle after acceptance and stays high, and the block keeps its master. In the cycle after free_vec shows a candidate, code 3 and the forward are issued and stall_err falls.
- R10: An eviction by a node that is not the master, an eviction of an untracked block, and req_op 3 are answered with code 4 (reject) and change no directory state.
- R11: While a long transaction is open, a request to the same block and any write or eviction are answered with code 5 (retry) and rsp_src set to the requester. Reads of other blocks are served normally.
- R12: req_ready is low exactly in the cycle in which an open transaction completes. Each accepted request gets one response. Acknowledgements that arrive with no write open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_node | input | NID_W | Requesting node |
| req_op | input | 2 | 0 read, 1 write, 2 master eviction, 3 reserved |
| req_addr | input | AW | Block address |
| rsp_valid | output | 1 | Response pulse |
| rsp_node | output | NID_W | Node the response is for |
| rsp_addr | output | AW | Block of the response |
| rsp_code | output | 3 | 0 first touch, 1 read grant, 2 write grant, 3 evict done, 4 reject, 5 retry |
| rsp_src | output | NID_W | Data supplier or new master, depending on the code |
| fwd_valid | output | 1 | Data-forward pulse |
| fwd_node | output | NID_W | Node that must send the block |
| fwd_dest | output | NID_W | Node that receives the block |
| fwd_addr | output | AW | Block to forward |
| inv_valid | output | 1 | Invalidate pulse |
| inv_vec | output | NODES | Nodes to invalidate |
| inv_addr | output | AW | Block to invalidate |
| ack_vec | input | NODES | Invalidate acknowledgements, one bit per node |
| free_vec | input | NODES | Nodes that can accept a master copy |
| stall_err | output | 1 | An eviction is waiting for capacity |

## Verification
Reads are driven by a new node, by the master and by a plain sharer, so a forward is seen to depend on holder status and not on whether the block is tracked. Writes are driven both with and without other sharers, and the acknowledgements are split across two cycles, which separates a grant on the last acknowledgement from a grant on the first one. Evictions cover the sharer-promotion, the free-node and the no-capacity paths, plus rejections, so each way of choosing a master can be told apart. Retries are provoked with same-block, other-block write, eviction and other-block read requests while a transaction is open, which confirms that only the clashing kinds are refused.

// File: rtl/amd_pkg.sv
// Shared encodings for the attraction-memory directory.
// Assumes the request and response codes below are fixed by the node interface.
package amd_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RSP_RD_FIRST = 3'd0,
        RSP_RD_GRANT = 3'd1,
        RSP_WR_GRANT = 3'd2,
        RSP_EV_DONE  = 3'd3,
        RSP_REJECT   = 3'd4,
        RSP_RETRY    = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_WR   = 2'd1,
        PEND_EV   = 2'd2
    } pend_e;

endpackage

// File: rtl/amd_entry_ram.sv
// Directory entry store: a valid bit, a sharer vector and a master id per block.
// Assumes BLOCKS is a power of two. The read is combinational and the write is
// synchronous. Only the valid bits are reset, and entries are never invalidated.
module amd_entry_ram #(
    parameter int unsigned NODES  = 4,
    parameter int unsigned BLOCKS = 16,
    localparam int NID_W = $clog2(NODES),
    localparam int AW    = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_valid,
    output logic [NODES-1:0] rd_sharers,
    output logic [NID_W-1:0] rd_master,
    input  logic             we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NODES-1:0] wr_sharers,
    input  logic [NID_W-1:0] wr_master
);

    logic [BLOCKS-1:0] vld_q;
    logic [NODES-1:0]  sh_mem [BLOCKS];
    logic [NID_W-1:0]  ms_mem [BLOCKS];

    // Track which blocks have ever been written into the directory.
    always_ff @(posedge clk) begin
        if (!rst_n)  vld_q <= '0;
        else if (we) vld_q[wr_addr] <= 1'b1;
    end

    // Store the sharer set and master id of the written entry.
    always_ff @(posedge clk) begin
        if (we) begin
            sh_mem[wr_addr] <= wr_sharers;
            ms_mem[wr_addr] <= wr_master;
        end
    end

    // Present the addressed entry without a pipeline stage.
    always_comb begin
        rd_valid   = vld_q[rd_addr];
        rd_sharers = sh_mem[rd_addr];
        rd_master  = ms_mem[rd_addr];
    end

endmodule

// File: rtl/amd_pick_low.sv
// Lowest-index finder over a request vector.
// Assumes W is at least 2. When nothing is set, idx is zero and found is low.
module amd_pick_low #(
    parameter int unsigned W = 4,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/amd_ack_track.sv
// Outstanding-invalidate tracker for the single open write.
// Assumes load and acks for the same node never arrive in the same cycle.
// Acks for nodes not in the mask are dropped.
module amd_ack_track #(
    parameter int unsigned NODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NODES-1:0] load_mask,
    input  logic [NODES-1:0] ack_vec,
    output logic             last
);

    logic [NODES-1:0] wait_q;

    // Load a fresh mask or retire the acknowledged nodes.
    always_ff @(posedge clk) begin
        if (!rst_n)    wait_q <= '0;
        else if (load) wait_q <= load_mask;
        else           wait_q <= wait_q & ~ack_vec;
    end

    // Flag the cycle in which the final outstanding node answers.
    always_comb last = (|wait_q) && ((wait_q & ~ack_vec) == '0);

endmodule

// File: rtl/amd_directory.sv
// Directory controller for a cache-only memory system with master-copy tracking.
// Assumes one request per cycle, at most one open long transaction (a write
// waiting for acks or an eviction waiting for capacity), and NODES and BLOCKS
// both powers of two. Responses, forwards and invalidates are one-cycle pulses.
module amd_directory
    import amd_pkg::*;
#(
    parameter int unsigned NODES  = 4,
    parameter int unsigned BLOCKS = 16,
    localparam int NID_W = $clog2(NODES),
    localparam int AW    = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [NID_W-1:0] req_node,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    output logic             rsp_valid,
    output logic [NID_W-1:0] rsp_node,
    output logic [AW-1:0]    rsp_addr,
    output logic [2:0]       rsp_code,
    output logic [NID_W-1:0] rsp_src,
    output logic             fwd_valid,
    output logic [NID_W-1:0] fwd_node,
    output logic [NID_W-1:0] fwd_dest,
    output logic [AW-1:0]    fwd_addr,
    output logic             inv_valid,
    output logic [NODES-1:0] inv_vec,
    output logic [AW-1:0]    inv_addr,
    input  logic [NODES-1:0] ack_vec,
    input  logic [NODES-1:0] free_vec,
    output logic             stall_err
);

    localparam logic [NODES-1:0] ONE = NODES'(1);

    op_e              op;
    logic             accept;
    logic [NODES-1:0] req_bit;

    logic             e_valid;
    logic [NODES-1:0] e_sharers;
    logic [NID_W-1:0] e_master;

    pend_e            pend_q;
    logic [AW-1:0]    pend_addr_q;
    logic [NID_W-1:0] pend_node_q;
    logic [NID_W-1:0] pend_src_q;
    logic [NODES-1:0] pend_bit;
    logic             pend_busy;
    logic             pend_done;
    logic             wr_done;
    logic             ev_done;
    logic             ack_last;

    logic [NODES-1:0] others;
    logic             oth_found, free_found, pfree_found;
    logic [NID_W-1:0] oth_idx, free_idx, pfree_idx;

    logic             n_rsp_v, n_fwd_v, n_inv_v;
    rsp_e             n_code;
    logic [NID_W-1:0] n_rsp_node, n_src, n_fwd_node, n_fwd_dest;
    logic [AW-1:0]    n_rsp_addr, n_fwd_addr;
    logic [NODES-1:0] n_inv_vec;
    logic             we;
    logic [AW-1:0]    w_addr;
    logic [NODES-1:0] w_sharers;
    logic [NID_W-1:0] w_master;
    logic             p_load;
    pend_e            p_kind;
    logic             set_stall;

    assign op       = op_e'(req_op);
    assign req_bit  = ONE << req_node;
    assign pend_bit = ONE << pend_node_q;
    assign others   = e_sharers & ~req_bit;

    amd_entry_ram #(.NODES(NODES), .BLOCKS(BLOCKS)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (req_addr),
        .rd_valid   (e_valid),
        .rd_sharers (e_sharers),
        .rd_master  (e_master),
        .we         (we),
        .wr_addr    (w_addr),
        .wr_sharers (w_sharers),
        .wr_master  (w_master)
    );

    amd_pick_low #(.W(NODES)) u_pick_oth (
        .vec (others), .found (oth_found), .idx (oth_idx)
    );

    amd_pick_low #(.W(NODES)) u_pick_free (
        .vec (free_vec & ~req_bit), .found (free_found), .idx (free_idx)
    );

    amd_pick_low #(.W(NODES)) u_pick_pfree (
        .vec (free_vec & ~pend_bit), .found (pfree_found), .idx (pfree_idx)
    );

    amd_ack_track #(.NODES(NODES)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (p_load && (p_kind == PEND_WR)),
        .load_mask (others),
        .ack_vec   (ack_vec),
        .last      (ack_last)
    );

    // Detect completion of the open transaction and block new requests then.
    always_comb begin
        pend_busy = (pend_q != PEND_NONE);
        wr_done   = (pend_q == PEND_WR) && ack_last;
        ev_done   = (pend_q == PEND_EV) && pfree_found;
        pend_done = wr_done || ev_done;
        req_ready = !pend_done;
        accept    = req_valid && req_ready;
    end

    // Decide the response, the messages and the directory update for this cycle.
    always_comb begin
        n_rsp_v    = 1'b0;
        n_code     = RSP_RETRY;
        n_rsp_node = req_node;
        n_rsp_addr = req_addr;
        n_src      = req_node;
        n_fwd_v    = 1'b0;
        n_fwd_node = e_master;
        n_fwd_dest = req_node;
        n_fwd_addr = req_addr;
        n_inv_v    = 1'b0;
        n_inv_vec  = '0;
        we         = 1'b0;
        w_addr     = req_addr;
        w_sharers  = req_bit;
        w_master   = req_node;
        p_load     = 1'b0;
        p_kind     = PEND_NONE;
        set_stall  = 1'b0;
        if (wr_done) begin
            n_rsp_v    = 1'b1;
            n_code     = RSP_WR_GRANT;
            n_rsp_node = pend_node_q;
            n_rsp_addr = pend_addr_q;
            n_src      = pend_src_q;
        end else if (ev_done) begin
            n_rsp_v    = 1'b1;
            n_code     = RSP_EV_DONE;
            n_rsp_node = pend_node_q;
            n_rsp_addr = pend_addr_q;
            n_src      = pfree_idx;
            n_fwd_v    = 1'b1;
            n_fwd_node = pend_node_q;
            n_fwd_dest = pfree_idx;
            n_fwd_addr = pend_addr_q;
            we         = 1'b1;
            w_addr     = pend_addr_q;
            w_sharers  = ONE << pfree_idx;
            w_master   = pfree_idx;
        end else if (accept) begin
            n_rsp_v = 1'b1;
            if (pend_busy && (req_addr == pend_addr_q || op != OP_RD)) begin
                n_code = RSP_RETRY;
            end else begin
                unique case (op)
                    OP_RD: begin
                        if (!e_valid) begin
                            n_code = RSP_RD_FIRST;
                            we     = 1'b1;
                        end else begin
                            n_code = RSP_RD_GRANT;
                            n_src  = e_master;
                            if (!e_sharers[req_node]) begin
                                n_fwd_v   = 1'b1;
                                we        = 1'b1;
                                w_sharers = e_sharers | req_bit;
                                w_master  = e_master;
                            end
                        end
                    end
                    OP_WR: begin
                        we = 1'b1;
                        if (!e_valid || !oth_found) begin
                            n_code = RSP_WR_GRANT;
                        end else begin
                            n_rsp_v   = 1'b0;
                            n_inv_v   = 1'b1;
                            n_inv_vec = others;
                            n_fwd_v   = !e_sharers[req_node];
                            p_load    = 1'b1;
                            p_kind    = PEND_WR;
                        end
                    end
                    OP_EV: begin
                        if (!e_valid || e_master != req_node) begin
                            n_code = RSP_REJECT;
                        end else if (oth_found) begin
                            n_code    = RSP_EV_DONE;
                            n_src     = oth_idx;
                            we        = 1'b1;
                            w_sharers = others;
                            w_master  = oth_idx;
                        end else if (free_found) begin
                            n_code     = RSP_EV_DONE;
                            n_src      = free_idx;
                            n_fwd_v    = 1'b1;
                            n_fwd_node = req_node;
                            n_fwd_dest = free_idx;
                            we         = 1'b1;
                            w_sharers  = ONE << free_idx;
                            w_master   = free_idx;
                        end else begin
                            n_rsp_v   = 1'b0;
                            p_load    = 1'b1;
                            p_kind    = PEND_EV;
                            set_stall = 1'b1;
                        end
                    end
                    default: n_code = RSP_REJECT;
                endcase
            end
        end
    end

    // Hold the single open transaction and the capacity stall flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= PEND_NONE;
            pend_addr_q <= '0;
            pend_node_q <= '0;
            pend_src_q  <= '0;
            stall_err   <= 1'b0;
        end else begin
            if (pend_done) begin
                pend_q <= PEND_NONE;
            end else if (p_load) begin
                pend_q      <= p_kind;
                pend_addr_q <= req_addr;
                pend_node_q <= req_node;
                pend_src_q  <= e_master;
            end
            if (ev_done)        stall_err <= 1'b0;
            else if (set_stall) stall_err <= 1'b1;
        end
    end

    // Register the outgoing response, forward and invalidate pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_node  <= '0;
            rsp_addr  <= '0;
            rsp_code  <= '0;
            rsp_src   <= '0;
            fwd_valid <= 1'b0;
            fwd_node  <= '0;
            fwd_dest  <= '0;
            fwd_addr  <= '0;
            inv_valid <= 1'b0;
            inv_vec   <= '0;
            inv_addr  <= '0;
        end else begin
            rsp_valid <= n_rsp_v;
            rsp_node  <= n_rsp_node;
            rsp_addr  <= n_rsp_addr;
            rsp_code  <= n_code;
            rsp_src   <= n_src;
            fwd_valid <= n_fwd_v;
            fwd_node  <= n_fwd_node;
            fwd_dest  <= n_fwd_dest;
            fwd_addr  <= n_fwd_addr;
            inv_valid <= n_inv_v;
            inv_vec   <= n_inv_vec;
            inv_addr  <= req_addr;
        end
    end

endmodule

// File: rtl/amd_directory_chk.sv
// Protocol checker for amd_directory, attached with bind.
// Assumes the response code encoding from amd_pkg.
module amd_directory_chk #(
    parameter int unsigned NODES  = 4,
    parameter int unsigned BLOCKS = 16,
    localparam int NID_W = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [NID_W-1:0] req_node,
    input logic [1:0]       req_op,
    input logic             rsp_valid,
    input logic [NID_W-1:0] rsp_node,
    input logic [2:0]       rsp_code,
    input logic [NID_W-1:0] rsp_src,
    input logic             fwd_valid,
    input logic [NID_W-1:0] fwd_node,
    input logic [NID_W-1:0] fwd_dest,
    input logic             inv_valid,
    input logic [NODES-1:0] inv_vec,
    input logic             stall_err,
    input logic             pend_done,
    input logic             pend_busy
);

    // R12
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(pend_done)));

    // R12
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> pend_busy);

    // R2
    first_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd0) |-> (rsp_src == rsp_node));

    // R4
    inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_vec != '0) && !inv_vec[$past(req_node)]));

    // R3
    fwd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_node != fwd_dest));

    // R9
    stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_err) |-> ($past(req_valid && req_ready) && $past(req_op) == 2'd2));

    // R11
    retry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd5) |-> (rsp_src == rsp_node));

endmodule

bind amd_directory amd_directory_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_node  (req_node),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_node  (rsp_node),
    .rsp_code  (rsp_code),
    .rsp_src   (rsp_src),
    .fwd_valid (fwd_valid),
    .fwd_node  (fwd_node),
    .fwd_dest  (fwd_dest),
    .inv_valid (inv_valid),
    .inv_vec   (inv_vec),
    .stall_err (stall_err),
    .pend_done (pend_done),
    .pend_busy (pend_busy)
);

// File: tb/tb_amd_directory.sv
module tb_amd_directory;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int B  = 16;
    localparam int NW = 2;
    localparam int AW = 4;

    localparam logic [2:0] C_FIRST = 3'd0, C_RDG = 3'd1, C_WRG = 3'd2,
                           C_EVD = 3'd3, C_REJ = 3'd4, C_RETRY = 3'd5;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready;
    logic [NW-1:0] req_node;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic rsp_valid;
    logic [NW-1:0] rsp_node, rsp_src;
    logic [AW-1:0] rsp_addr;
    logic [2:0]    rsp_code;
    logic fwd_valid;
    logic [NW-1:0] fwd_node, fwd_dest;
    logic [AW-1:0] fwd_addr;
    logic inv_valid;
    logic [N-1:0]  inv_vec;
    logic [AW-1:0] inv_addr;
    logic [N-1:0]  ack_vec, free_vec;
    logic stall_err;

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic [NW-1:0] node;
        logic [AW-1:0] addr;
        logic [2:0]    code;
        logic [NW-1:0] src;
        logic [7:0]    tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    amd_directory #(.NODES(N), .BLOCKS(B)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
        .req_op(req_op), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_addr(rsp_addr),
        .rsp_code(rsp_code), .rsp_src(rsp_src),
        .fwd_valid(fwd_valid), .fwd_node(fwd_node), .fwd_dest(fwd_dest),
        .fwd_addr(fwd_addr),
        .inv_valid(inv_valid), .inv_vec(inv_vec), .inv_addr(inv_addr),
        .ack_vec(ack_vec), .free_vec(free_vec), .stall_err(stall_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard: push one expected response; tag is the requirement number.
    task automatic expect_rsp(input int node, input int addr, input logic [2:0] code,
                              input int src, input int tag);
        exp_t e;
        e.node = NW'(node);
        e.addr = AW'(addr);
        e.code = code;
        e.src  = NW'(src);
        e.tag  = 8'(tag);
        exp_q.push_back(e);
    endtask

    // Driver: present one request for one cycle, return at the next falling edge.
    task automatic send(input int node, input int op, input int addr);
        req_node  = NW'(node);
        req_op    = 2'(op);
        req_addr  = AW'(addr);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_fwd(input string tag, input int src, input int dst, input int addr);
        chk({tag, " fwd_valid"}, 32'(fwd_valid), 32'd1);
        chk({tag, " fwd_node"},  32'(fwd_node),  32'(src));
        chk({tag, " fwd_dest"},  32'(fwd_dest),  32'(dst));
        chk({tag, " fwd_addr"},  32'(fwd_addr),  32'(addr));
    endtask

    // Monitor: compare each response against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R12 unexpected response actual code=%0d node=%0d expected none",
                         rsp_code, rsp_node);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_node !== e.node || rsp_addr !== e.addr ||
                    rsp_code !== e.code || rsp_src !== e.src) begin
                    failures++;
                    $display("FAIL R%0d response actual node=%0d addr=%0d code=%0d src=%0d expected node=%0d addr=%0d code=%0d src=%0d",
                             e.tag, rsp_node, rsp_addr, rsp_code, rsp_src,
                             e.node, e.addr, e.code, e.src);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_node = '0; req_op = '0; req_addr = '0;
        ack_vec = '0; free_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 fwd_valid", 32'(fwd_valid), 0);
        chk("R1 inv_valid", 32'(inv_valid), 0);
        chk("R1 stall_err", 32'(stall_err), 0);
        chk("R1 req_ready", 32'(req_ready), 1);

        // R2 first touch of block 3 by node 1
        expect_rsp(1, 3, C_FIRST, 1, 2); send(1, 0, 3);
        chk("R2 no fwd", 32'(fwd_valid), 0);

        // R3 non-holder read forwarded from master 1
        expect_rsp(2, 3, C_RDG, 1, 3); send(2, 0, 3);
        chk_fwd("R3", 1, 2, 3);
        expect_rsp(2, 3, C_RDG, 1, 3); send(2, 0, 3);
        chk("R3 holder reread no fwd", 32'(fwd_valid), 0);
        expect_rsp(0, 3, C_RDG, 1, 3); send(0, 0, 3);
        chk_fwd("R3 node0", 1, 0, 3);

        // R10 eviction by a non-master is rejected, master unchanged
        expect_rsp(2, 3, C_REJ, 2, 10); send(2, 2, 3);
        chk("R10 no fwd", 32'(fwd_valid), 0);
        expect_rsp(3, 3, C_RDG, 1, 10); send(3, 0, 3);
        chk_fwd("R10 master kept", 1, 3, 3);
        // R10 eviction of untracked block rejected and leaves it untracked
        expect_rsp(0, 12, C_REJ, 0, 10); send(0, 2, 12);
        expect_rsp(1, 12, C_FIRST, 1, 10); send(1, 0, 12);

        // R7 master 1 evicts, sharers {0,2,3}: node 0 promoted, no data moved
        expect_rsp(1, 3, C_EVD, 0, 7); send(1, 2, 3);
        chk("R7 no fwd", 32'(fwd_valid), 0);

        // R4 node 3 writes block 3 shared by {0,2,3}
        send(3, 1, 3);
        chk("R4 inv_valid", 32'(inv_valid), 1);
        chk("R4 inv_vec", 32'(inv_vec), 32'b0101);
        chk("R4 inv_addr", 32'(inv_addr), 3);
        chk("R4 no fwd for holder", 32'(fwd_valid), 0);
        // R11 clashing requests while the write is open
        expect_rsp(1, 3, C_RETRY, 1, 11); send(1, 0, 3);
        chk("R4 inv single pulse", 32'(inv_valid), 0);
        expect_rsp(1, 5, C_RETRY, 1, 11); send(1, 1, 5);
        expect_rsp(1, 5, C_FIRST, 1, 11); send(1, 0, 5);
        // R4 first ack does not complete the write
        ack_vec = 4'b0001;
        #1 chk("R12 ready with ack pending", 32'(req_ready), 1);
        @(negedge clk); ack_vec = '0;
        // R4 last ack completes it; R12 ready drops in that cycle
        ack_vec = 4'b0100;
        #1 chk("R12 ready low on completion", 32'(req_ready), 0);
        expect_rsp(3, 3, C_WRG, 0, 4);
        @(negedge clk); ack_vec = '0;

        // R6 writer 3 is the master now
        expect_rsp(1, 3, C_RDG, 3, 6); send(1, 0, 3);
        chk_fwd("R6", 3, 1, 3);

        // R5 write to untracked block and rewrite by sole holder
        expect_rsp(2, 7, C_WRG, 2, 5); send(2, 1, 7);
        chk("R5 no inv", 32'(inv_valid), 0);
        expect_rsp(2, 7, C_WRG, 2, 5); send(2, 1, 7);
        chk("R5 no inv again", 32'(inv_valid), 0);

        // R8 sole holder 2 evicts, free {1,3}: node 1 chosen
        free_vec = 4'b1010;
        expect_rsp(2, 7, C_EVD, 1, 8); send(2, 2, 7);
        chk_fwd("R8", 2, 1, 7);
        free_vec = '0;
        expect_rsp(3, 7, C_RDG, 1, 8); send(3, 0, 7);
        chk_fwd("R8 new master", 1, 3, 7);

        // R9 no capacity: node 0 sole holder of block 9, only itself free
        expect_rsp(0, 9, C_WRG, 0, 5); send(0, 1, 9);
        free_vec = 4'b0001;
        send(0, 2, 9);
        chk("R9 stall high", 32'(stall_err), 1);
        @(negedge clk); @(negedge clk);
        chk("R9 stall held", 32'(stall_err), 1);
        expect_rsp(2, 9, C_RETRY, 2, 11); send(2, 0, 9);
        expect_rsp(1, 3, C_RETRY, 1, 11); send(1, 2, 3);
        chk("R9 stall still held", 32'(stall_err), 1);
        free_vec = 4'b0100;
        #1 chk("R12 ready low on evict completion", 32'(req_ready), 0);
        expect_rsp(0, 9, C_EVD, 2, 9);
        @(negedge clk);
        free_vec = '0;
        chk_fwd("R9", 0, 2, 9);
        chk("R9 stall cleared", 32'(stall_err), 0);
        expect_rsp(3, 9, C_RDG, 2, 9); send(3, 0, 9);
        chk_fwd("R9 new master", 2, 3, 9);

        // R12 stray acks with no open write are ignored
        ack_vec = 4'b1111;
        @(negedge clk); ack_vec = '0;
        @(negedge clk);
        chk("R12 stray ack no rsp", 32'(rsp_valid), 0);
        chk("R12 ready after stray ack", 32'(req_ready), 1);

        repeat (2) @(negedge clk);
        chk("R12 all responses seen", 32'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule